// File: doc/BRIEF.md
# Clock-Loss Power Mode Controller

This block chooses the operating state of a mixed-signal converter front end. Two things decide the state: a 3-bit mode field and whether the master clock is running. A free-running reference clock times the gaps between master-clock edges. When the gap grows too long, a watchdog pulls the block into power down, whatever the mode field holds. The block then stays in power down until the master clock is running again.

While the master clock runs, the mode field is synchronized and filtered, then decoded into one of four states: modulator, AC test, DC test or sleep. From the state the block drives four enables: modulator, AC test generator, DC test generator, and a global output enable that controls high impedance. The analog circuits behind these enables are outside the block. Every pin is a plain control or status level, so the block has no valid/ready interface and applies no back-pressure.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and after release until two master-clock edges have been seen, `state_o` is 0 (power down) and `mod_en`, `ac_en`, `dc_en` and `out_en` are all low.
- R2: After TIMEOUT_US × REF_KHZ / 1000 reference cycles (default 40) with no master-clock rising edge, the block enters power down, whatever `mode_in` holds. It stays in the previous state for at least 25 cycles after the last edge, and it is in power down no later than 52 cycles after the last edge.
- R3: Power down is left only when a detected master-clock edge arrives less than the timeout after the previous detected edge. A single isolated edge leaves the block in power down. Rising edges spaced at least 3 reference cycles apart are each detected.
- R4: Mode code 0 gives the modulator state: `state_o`=2, `mod_en`=1, `out_en`=1, `ac_en`=0, `dc_en`=0.
- R5: Mode codes 1, 2, 3 and 6 give the AC test state: `state_o`=3, `mod_en`=1, `out_en`=1, `dc_en`=0. In this state `ac_en` equals the synchronized `tdata_valid`, and the block stays in AC test while `tdata_valid` changes.
- R6: Mode codes 4 and 5 give the DC test state: `state_o`=4, `mod_en`=1, `dc_en`=1, `out_en`=1, `ac_en`=0.
- R7: Mode code 7 gives sleep: `state_o`=1 with all four enables low.
- R8: In power down (`state_o`=0), all four enables are low whatever `mode_in` and `tdata_valid` hold.
- R9: A `mode_in` value held for two or more reference cycles reaches the outputs within 6 reference cycles. A value held for only one cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock that times the watchdog |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk | input | 1 | Master clock being monitored |
| mode_in | input | 3 | Requested operating mode code |
| tdata_valid | input | 1 | Test data stream valid; gates the AC generator |
| state_o | output | 3 | Current state: 0 down, 1 sleep, 2 modulator, 3 AC test, 4 DC test |
| mod_en | output | 1 | Modulator enable |
| ac_en | output | 1 | AC test generator enable |
| dc_en | output | 1 | DC test generator enable |
| out_en | output | 1 | Global output enable (low means high impedance) |

## Verification
The hardest case to reach from the ports is the rule that edges must be consecutive to leave power down. The clock has to stop long enough for the watchdog to saturate, then come back as single pulses with chosen gaps. The bench stops the free-running master clock and injects hand-made pulses. The first pulse is isolated. The second comes after more than the timeout, so the block must still be in power down. The third follows shortly after the second, and only then may the block leave power down. One-cycle glitches on the mode field are driven between falling edges, so that the synchronizer captures each glitch exactly once.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PM_DOWN  = 3'd0,
    PM_SLEEP = 3'd1,
    PM_MOD   = 3'd2,
    PM_ACT   = 3'd3,
    PM_DCT   = 3'd4
  } pm_state_e;

  // Map a filtered mode code to its operating state.
  function automatic pm_state_e pm_decode(input logic [2:0] code);
    pm_state_e s;
    case (code)
      3'd0:                 s = PM_MOD;
      3'd4, 3'd5:           s = PM_DCT;
      3'd7:                 s = PM_SLEEP;
      default:              s = PM_ACT;   // 1, 2, 3, 6
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pmc_clk_watchdog.sv
module pmc_clk_watchdog #(
  parameter int TERM = 40
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mclk,
  output logic edge_o,
  output logic lost_o
);

  localparam int CW = $clog2(TERM + 1);
  localparam logic [CW-1:0] TERM_C = CW'(TERM);

  // Toggle flop in the master-clock domain: each rising edge flips it.
  logic tgl;
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end

  logic tgl_s, tgl_d;
  pmc_sync #(.W(1), .STAGES(2)) u_tsync (
    .clk(ref_clk), .rst_n(rst_n), .d(tgl), .q(tgl_s)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) tgl_d <= 1'b0;
    else        tgl_d <= tgl_s;
  end

  assign edge_o = tgl_s ^ tgl_d;

  // Gap counter: starts saturated so reset looks like a lost clock.
  logic [CW-1:0] cnt;
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)              cnt <= TERM_C;
    else if (edge_o)         cnt <= '0;
    else if (cnt != TERM_C)  cnt <= cnt + CW'(1);
  end

  assign lost_o = (cnt == TERM_C);

  assert_edge_clears_loss_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $past(edge_o) |-> !lost_o);

  assert_loss_needs_quiet_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(lost_o) |-> $past(!edge_o));

endmodule

// File: rtl/pmc_mode_filter.sv
module pmc_mode_filter #(
  parameter int MW = 3
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode_in,
  output logic [MW-1:0] mode_q
);

  logic [MW-1:0] m_s, m_d;

  pmc_sync #(.W(MW), .STAGES(2)) u_msync (
    .clk(ref_clk), .rst_n(rst_n), .d(mode_in), .q(m_s)
  );

  // Accept a value only once two successive samples agree.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_d    <= '0;
      mode_q <= '0;
    end else begin
      m_d <= m_s;
      if (m_s == m_d) mode_q <= m_s;
    end
  end

  assert_mode_only_when_stable_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(m_s == m_d));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int REF_KHZ    = 1000,
  parameter int TIMEOUT_US = 40
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       mclk,
  input  logic [2:0] mode_in,
  input  logic       tdata_valid,
  output logic [2:0] state_o,
  output logic       mod_en,
  output logic       ac_en,
  output logic       dc_en,
  output logic       out_en
);
  import pmc_pkg::*;

  localparam int TERM_RAW = (TIMEOUT_US * REF_KHZ) / 1000;
  localparam int TERM     = (TERM_RAW < 4) ? 4 : TERM_RAW;

  logic       mclk_edge, clk_lost;
  logic [2:0] mode_q;
  logic       tv_s;

  pmc_clk_watchdog #(.TERM(TERM)) u_wdog (
    .ref_clk(ref_clk), .rst_n(rst_n), .mclk(mclk),
    .edge_o(mclk_edge), .lost_o(clk_lost)
  );

  pmc_mode_filter #(.MW(3)) u_mfilt (
    .ref_clk(ref_clk), .rst_n(rst_n), .mode_in(mode_in), .mode_q(mode_q)
  );

  pmc_sync #(.W(1), .STAGES(2)) u_tvsync (
    .clk(ref_clk), .rst_n(rst_n), .d(tdata_valid), .q(tv_s)
  );

  pm_state_e state_q, state_nx;

  always_comb begin
    state_nx = state_q;
    if (clk_lost)                state_nx = PM_DOWN;
    else if (state_q != PM_DOWN) state_nx = pm_decode(mode_q);
    else if (mclk_edge)          state_nx = pm_decode(mode_q);
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_DOWN;
    else        state_q <= state_nx;
  end

  logic running;
  assign running = (state_q == PM_MOD) || (state_q == PM_ACT) || (state_q == PM_DCT);

  assign state_o = state_q;
  assign mod_en  = running;
  assign out_en  = running;
  assign dc_en   = (state_q == PM_DCT);
  assign ac_en   = (state_q == PM_ACT) && tv_s;

  assert_loss_forces_down_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    clk_lost |=> (state_q == PM_DOWN));

  assert_exit_needs_edge_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ((state_q != PM_DOWN) && ($past(state_q) == PM_DOWN)) |-> $past(mclk_edge));

  assert_idle_quiet_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ((state_q == PM_DOWN) || (state_q == PM_SLEEP)) |-> !(mod_en || ac_en || dc_en || out_en));

  assert_ac_gated_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ac_en |-> (tv_s && mod_en));

  assert_single_test_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(ac_en && dc_en));

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

  localparam int TERM = 40;

  logic       ref_clk = 1'b0;
  logic       rst_n;
  logic       mclk_free = 1'b0;
  logic       mclk_run, mclk_man;
  logic       mclk;
  logic [2:0] mode_in;
  logic       tdata_valid;
  logic [2:0] state_o;
  logic       mod_en, ac_en, dc_en, out_en;

  int vectors = 0;
  int errors  = 0;

  always #5  ref_clk   = ~ref_clk;
  always #35 mclk_free = ~mclk_free;
  assign mclk = (mclk_free & mclk_run) | mclk_man;

  pwr_mode_ctrl u_dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .mclk(mclk), .mode_in(mode_in),
    .tdata_valid(tdata_valid), .state_o(state_o), .mod_en(mod_en),
    .ac_en(ac_en), .dc_en(dc_en), .out_en(out_en)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // {state, mod, ac, dc, oe} expected for a running clock
  function automatic logic [6:0] expect_run(input logic [2:0] m, input logic tv);
    case (m)
      3'd0:       return {3'd2, 1'b1, 1'b0, 1'b0, 1'b1};
      3'd7:       return {3'd1, 1'b0, 1'b0, 1'b0, 1'b0};
      3'd4, 3'd5: return {3'd4, 1'b1, 1'b0, 1'b1, 1'b1};
      default:    return {3'd3, 1'b1, tv,   1'b0, 1'b1};
    endcase
  endfunction

  localparam logic [6:0] DOWN_V = 7'b000_0000;

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {state_o, mod_en, ac_en, dc_en, out_en};
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got state=%0d en=%b expected state=%0d en=%b",
               req, act[6:4], act[3:0], exp[6:4], exp[3:0]);
    end
  endtask

  task automatic pulse();
    mclk_man = 1'b1; cyc(2);
    mclk_man = 1'b0; cyc(2);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_in = 3'd0; tdata_valid = 1'b0;
    mclk_run = 1'b0; mclk_man = 1'b0;
    cyc(3);
    check("R1 in reset", DOWN_V);
    rst_n = 1'b1;
    cyc(10);
    check("R1 after release no clock", DOWN_V);

    // R3: running clock brings the block up
    mclk_run = 1'b1;
    cyc(40);
    check("R3 resume", expect_run(3'd0, 1'b0));

    // R4..R7, R9: every mode-to-mode transition, both tdata_valid levels
    for (int p = 0; p < 8; p++) begin
      for (int n = 0; n < 8; n++) begin
        for (int t = 0; t < 2; t++) begin
          mode_in = 3'(p); tdata_valid = 1'b0;
          cyc(8);
          mode_in = 3'(n); tdata_valid = t[0];
          cyc(6);
          check("R4-7 sweep R9 latency", expect_run(3'(n), t[0]));
        end
      end
    end

    // R5: tdata_valid toggles inside AC test
    mode_in = 3'd6; tdata_valid = 1'b1; cyc(8);
    check("R5 ac on", expect_run(3'd6, 1'b1));
    tdata_valid = 1'b0; cyc(4);
    check("R5 ac gated off", expect_run(3'd6, 1'b0));
    tdata_valid = 1'b1; cyc(4);
    check("R5 ac back on", expect_run(3'd6, 1'b1));

    // R9: one-cycle glitches are ignored
    mode_in = 3'd0; tdata_valid = 1'b1; cyc(8);
    for (int g = 1; g < 8; g++) begin
      mode_in = 3'(g); cyc(1);
      mode_in = 3'd0;
      for (int k = 0; k < 8; k++) begin
        cyc(1);
        check("R9 glitch ignored", expect_run(3'd0, 1'b1));
      end
    end

    // R2: clock stops
    mode_in = 3'd4; cyc(8);
    check("R2 before stop", expect_run(3'd4, 1'b1));
    mclk_run = 1'b0;
    cyc(25);
    check("R2 still up early", expect_run(3'd4, 1'b1));
    cyc(TERM - 13);
    check("R2 down after timeout", DOWN_V);

    // R8: mode and tdata_valid have no effect in power down
    for (int m = 0; m < 8; m++) begin
      mode_in = 3'(m); tdata_valid = m[0];
      cyc(8);
      check("R8 down ignores mode", DOWN_V);
    end

    // R3: isolated edges keep power down, consecutive pair leaves it
    mode_in = 3'd1; tdata_valid = 1'b1; cyc(8);
    pulse(); cyc(8);
    check("R3 first isolated edge", DOWN_V);
    cyc(TERM + 10);
    pulse(); cyc(8);
    check("R3 second edge after gap", DOWN_V);
    pulse(); cyc(4);
    check("R3 consecutive pair exits", expect_run(3'd1, 1'b1));
    cyc(TERM + 20);
    check("R2 manual clock lost again", DOWN_V);

    // R1: reset during operation returns to power down
    mclk_run = 1'b1; cyc(40);
    check("R3 resume again", expect_run(3'd1, 1'b1));
    rst_n = 1'b0; cyc(2);
    check("R1 reset mid-run", DOWN_V);
    rst_n = 1'b1; cyc(40);
    check("R3 up after reset", expect_run(3'd1, 1'b1));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule